// File: doc/BRIEF.md
# Double-Edge Burst Write Capture

This block is the write half of a memory interface that moves two data beats per clock, one on the rising edge and one on the falling edge. A transfer opens when the active-low port select is seen low at a rising edge. The 18-bit data word and its two active-low byte selects present at that edge form the lower half of the transfer. At the falling edge that follows, the block takes the second 18-bit word with its own byte selects and the write address.

On the next rising edge the block presents one 36-bit array write. The write has a 4-bit lane-enable mask, one bit per 9-bit byte, and bytes whose select was high are zeroed. Once a transfer has opened, it finishes whatever the port select does afterwards.

An array placed behind the block updates only the enabled lanes at the presented address. A byte with a deasserted select therefore keeps its stored value.

Top module: `ddr_burst2_wr_port`

## Requirements
- R1: mem_we is high only for a transfer that was opened by wr_sel_n low at a rising edge.
- R2: With wr_sel_n high at a rising edge, no transfer opens. The data, byte selects and address around that edge have no effect, and mem_we stays low for that slot.
- R3: mem_data[17:0] carries the din value present at the opening rising edge.
- R4: mem_data[35:18] carries the din value, and mem_addr the wr_addr_in value, present at the falling edge right after the opening rising edge.
- R5: mem_lane bit k is 1 exactly when the byte select for byte k was low. Bits 0 and 1 come from bw_n[0] and bw_n[1] at the rising edge, and bits 2 and 3 come from bw_n[0] and bw_n[1] at the falling edge. Byte select bit 0 governs bits 8:0 of its word, and bit 1 governs bits 17:9.
- R6: Every 9-bit byte of mem_data whose lane bit is 0 is driven as zero. A transfer with all four selects high still issues, with mem_lane 0000.
- R7: mem_we rises on the first rising edge after the opening edge and lasts one clock unless the next slot also opened a transfer. When idle, mem_lane is 0.
- R8: Transfers opened on consecutive rising edges each produce their own array write, in order, on consecutive cycles.
- R9: wr_sel_n going high after the opening rising edge does not cancel the transfer.
- R10: rst_n low clears all pending state, so a transfer interrupted by reset never issues, and mem_we and mem_lane read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge and falling edge are both capture points |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel_n | input | 1 | Active-low port select, sampled on rising edges |
| bw_n | input | 2 | Active-low byte selects for the current 18-bit beat |
| din | input | 18 | Data beat |
| wr_addr_in | input | AW | Write address, taken on the falling edge |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_lane | output | 4 | Per-byte write enables, lane 0 at the lowest byte |
| mem_data | output | 36 | Merged write data, disabled bytes zero |

## Verification
The bench changes din, bw_n and wr_sel_n between the two edges of every cycle. A design that sampled either beat on the wrong edge, or that swapped the halves, would put the second word in the low half or repeat one word twice. Transfers with every byte masked, a mixed per-beat mask and back-to-back openings are aimed at designs that drop a masked transfer, reuse the first beat's mask for the second beat, or lose a write when the pipeline is busy every cycle. Reset in the middle of a transfer and deselect right after the opening edge separate a design that cancels too eagerly from one that leaks a stale write.

// File: rtl/ddrw_pkg.sv
`timescale 1ns/1ps
package ddrw_pkg;
  localparam int unsigned DDRW_BYTE_W   = 9;
  localparam int unsigned DDRW_NBYTES   = 2;
  localparam int unsigned DDRW_ADDR_W   = 18;
endpackage

// File: rtl/ddrw_rise_cap.sv
`timescale 1ns/1ps
module ddrw_rise_cap
  import ddrw_pkg::*;
#(
  parameter int unsigned BYTE_W = DDRW_BYTE_W,
  parameter int unsigned NB     = DDRW_NBYTES,
  localparam int unsigned WORD_W = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic [NB-1:0]     be_n,
  input  logic [WORD_W-1:0] din,
  output logic              start_q,
  output logic [WORD_W-1:0] lo_word_q,
  output logic [NB-1:0]     lo_en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= 1'b0;
      lo_word_q <= '0;
      lo_en_q   <= '0;
    end else begin
      start_q <= !sel_n;
      if (!sel_n) begin
        lo_word_q <= din;
        lo_en_q   <= ~be_n;
      end
    end
  end

  // R2
  lo_hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(lo_word_q))
    else $error("low beat changed while deselected");
endmodule

// File: rtl/ddrw_fall_cap.sv
`timescale 1ns/1ps
module ddrw_fall_cap
  import ddrw_pkg::*;
#(
  parameter int unsigned BYTE_W = DDRW_BYTE_W,
  parameter int unsigned NB     = DDRW_NBYTES,
  parameter int unsigned AW     = DDRW_ADDR_W,
  localparam int unsigned WORD_W = BYTE_W * NB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_q,
  input  logic [NB-1:0]     be_n,
  input  logic [WORD_W-1:0] din,
  input  logic [AW-1:0]     addr,
  output logic              valid_q,
  output logic [WORD_W-1:0] hi_word_q,
  output logic [NB-1:0]     hi_en_q,
  output logic [AW-1:0]     addr_q
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      hi_word_q <= '0;
      hi_en_q   <= '0;
      addr_q    <= '0;
    end else begin
      valid_q <= start_q;
      if (start_q) begin
        hi_word_q <= din;
        hi_en_q   <= ~be_n;
        addr_q    <= addr;
      end
    end
  end

  // R2
  addr_ignored_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !start_q |=> $stable(addr_q))
    else $error("address taken without an open transfer");
endmodule

// File: rtl/ddrw_issue.sv
`timescale 1ns/1ps
module ddrw_issue
  import ddrw_pkg::*;
#(
  parameter int unsigned BYTE_W = DDRW_BYTE_W,
  parameter int unsigned NB     = DDRW_NBYTES,
  parameter int unsigned AW     = DDRW_ADDR_W,
  localparam int unsigned WORD_W = BYTE_W * NB,
  localparam int unsigned LANES  = 2 * NB,
  localparam int unsigned DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [WORD_W-1:0] lo_word,
  input  logic [NB-1:0]     lo_en,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [NB-1:0]     hi_en,
  input  logic [AW-1:0]     addr,
  output logic              we_q,
  output logic [AW-1:0]     addr_q,
  output logic [LANES-1:0]  lane_q,
  output logic [DATA_W-1:0] data_q
);
  function automatic logic [DATA_W-1:0] mask_merge(
    input logic [WORD_W-1:0] lo, input logic [WORD_W-1:0] hi,
    input logic [LANES-1:0] en);
    logic [DATA_W-1:0] cat;
    logic [DATA_W-1:0] res;
    cat = {hi, lo};
    res = '0;
    for (int i = 0; i < LANES; i++)
      if (en[i]) res[i*BYTE_W +: BYTE_W] = cat[i*BYTE_W +: BYTE_W];
    return res;
  endfunction

  logic [LANES-1:0] lane_d;
  assign lane_d = {hi_en, lo_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      lane_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= valid;
      if (valid) begin
        addr_q <= addr;
        lane_q <= lane_d;
        data_q <= mask_merge(lo_word, hi_word, lane_d);
      end else begin
        lane_q <= '0;
        data_q <= '0;
      end
    end
  end

  // R7
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_q |-> (lane_q == '0))
    else $error("lanes enabled with no write");

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R6
    masked_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_q[g] |-> (data_q[g*BYTE_W +: BYTE_W] == '0))
      else $error("disabled byte %0d carries data", g);
  end
endmodule

// File: rtl/ddr_burst2_wr_port.sv
`timescale 1ns/1ps
module ddr_burst2_wr_port
  import ddrw_pkg::*;
#(
  parameter int unsigned AW     = DDRW_ADDR_W,
  parameter int unsigned BYTE_W = DDRW_BYTE_W,
  parameter int unsigned NB     = DDRW_NBYTES,
  localparam int unsigned WORD_W = BYTE_W * NB,
  localparam int unsigned LANES  = 2 * NB,
  localparam int unsigned DATA_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel_n,
  input  logic [NB-1:0]     bw_n,
  input  logic [WORD_W-1:0] din,
  input  logic [AW-1:0]     wr_addr_in,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_lane,
  output logic [DATA_W-1:0] mem_data
);
  logic              start_evt;
  logic              fall_evt;
  logic [WORD_W-1:0] lo_word, hi_word;
  logic [NB-1:0]     lo_en, hi_en;
  logic [AW-1:0]     cap_addr;

  ddrw_rise_cap #(.BYTE_W(BYTE_W), .NB(NB)) u_rise (
    .clk(clk), .rst_n(rst_n), .sel_n(wr_sel_n), .be_n(bw_n), .din(din),
    .start_q(start_evt), .lo_word_q(lo_word), .lo_en_q(lo_en));

  ddrw_fall_cap #(.BYTE_W(BYTE_W), .NB(NB), .AW(AW)) u_fall (
    .clk(clk), .rst_n(rst_n), .start_q(start_evt), .be_n(bw_n), .din(din),
    .addr(wr_addr_in), .valid_q(fall_evt), .hi_word_q(hi_word),
    .hi_en_q(hi_en), .addr_q(cap_addr));

  ddrw_issue #(.BYTE_W(BYTE_W), .NB(NB), .AW(AW)) u_issue (
    .clk(clk), .rst_n(rst_n), .valid(fall_evt), .lo_word(lo_word),
    .lo_en(lo_en), .hi_word(hi_word), .hi_en(hi_en), .addr(cap_addr),
    .we_q(mem_we), .addr_q(mem_addr), .lane_q(mem_lane), .data_q(mem_data));

  // R1
  we_has_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(start_evt))
    else $error("write with no opening edge");

  // R7
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> mem_we)
    else $error("opened transfer did not issue next cycle");

  // R2
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel_n |-> ##2 !mem_we)
    else $error("write issued for a deselected slot");
endmodule

// File: tb/ddr_burst2_wr_port_tb.sv
`timescale 1ns/1ps
module ddr_burst2_wr_port_tb;
  localparam int AW = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_sel_n = 1'b1;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] din = '0;
  logic [AW-1:0] wr_addr_in = '0;
  logic        mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_lane;
  logic [35:0] mem_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic          exp_v = 1'b0;
  logic [AW-1:0] exp_a = '0;
  logic [3:0]    exp_l = '0;
  logic [35:0]   exp_d = '0;

  always #2.5 clk = ~clk;

  ddr_burst2_wr_port #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_sel_n(wr_sel_n), .bw_n(bw_n), .din(din),
    .wr_addr_in(wr_addr_in), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_lane(mem_lane), .mem_data(mem_data));

  function automatic logic [3:0] lanes_of(input logic [1:0] lo_b, input logic [1:0] hi_b);
    logic [3:0] r;
    for (int k = 0; k < 4; k++) begin
      logic b;
      b = (k < 2) ? lo_b[k] : hi_b[k-2];
      r[k] = (b == 1'b0) ? 1'b1 : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [35:0] merged(input logic [17:0] lo, input logic [17:0] hi,
                                         input logic [3:0] l);
    logic [35:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [17:0] w;
      logic [35:0] byt;
      w = (k < 2) ? lo : hi;
      byt = 36'((w >> ((k % 2) * 9)) & 18'h1ff);
      if (l[k]) r = r | (byt << (k * 9));
    end
    return r;
  endfunction

  function automatic logic [35:0] lane_bits(input logic [3:0] l);
    logic [35:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) if (l[k]) r = r | (36'h1ff << (k * 9));
    return r;
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, 64'(mem_we), 64'(exp_v));
    if (exp_v) begin
      chk("R4 address", 64'(mem_addr), 64'(exp_a));
      chk("R3 low word", 64'(mem_data[17:0]), 64'(exp_d[17:0]));
      chk("R4 high word", 64'(mem_data[35:18]), 64'(exp_d[35:18]));
      chk("R5 lane mask", 64'(mem_lane), 64'(exp_l));
      chk("R6 masked bytes zero", 64'(mem_data & ~lane_bits(mem_lane)), 64'd0);
    end else begin
      chk("R7 idle lanes", 64'(mem_lane), 64'd0);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic cyc(input bit sel, input logic [17:0] lo_d, input logic [1:0] lo_b,
                     input logic [17:0] hi_d, input logic [1:0] hi_b,
                     input logic [AW-1:0] a, input logic hi_sel_n,
                     input bit abort, input string tag);
    wr_sel_n = !sel; din = lo_d; bw_n = lo_b;
    @(posedge clk); #1;
    compare(tag);
    din = hi_d; bw_n = hi_b; wr_addr_in = a; wr_sel_n = hi_sel_n;
    if (sel && !abort) begin
      exp_v = 1'b1; exp_a = a;
      exp_l = lanes_of(lo_b, hi_b);
      exp_d = merged(lo_d, hi_d, exp_l);
    end else begin
      exp_v = 1'b0;
    end
    if (abort) rst_n = 1'b0;
    @(negedge clk); #1;
    if (abort) rst_n = 1'b1;
  endtask

  task automatic rnd_cyc(input string tag);
    cyc($urandom % 3 != 0, 18'($urandom), 2'($urandom), 18'($urandom), 2'($urandom),
        AW'($urandom), 1'($urandom), 1'b0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #7;
    chk("R10 reset write strobe", 64'(mem_we), 64'd0);
    chk("R10 reset lanes", 64'(mem_lane), 64'd0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #1;

    cyc(1, 18'h2_1a5c, 2'b00, 18'h3_0f0f, 2'b00, 18'h0_0011, 1'b1, 1'b0, "R2 idle before first write");
    cyc(0, 18'h1_1111, 2'b00, 18'h2_2222, 2'b00, 18'h0_0022, 1'b1, 1'b0, "R1 full write issued");
    cyc(0, 18'h0_0000, 2'b00, 18'h0_0000, 2'b00, 18'h0_0033, 1'b1, 1'b0, "R7 single-cycle strobe");
    cyc(1, 18'h3_ffff, 2'b11, 18'h3_ffff, 2'b11, 18'h3_ffff, 1'b1, 1'b0, "R2 idle slot");
    cyc(1, 18'h1_2345, 2'b10, 18'h2_6789, 2'b01, 18'h1_0101, 1'b1, 1'b0, "R6 all-masked write issues");
    cyc(1, 18'h0_abcd, 2'b01, 18'h3_dcba, 2'b10, 18'h2_0202, 1'b0, 1'b0, "R5 mixed mask write");
    cyc(1, 18'h2_aaaa, 2'b00, 18'h1_5555, 2'b00, 18'h3_0303, 1'b1, 1'b0, "R8 back-to-back write");
    cyc(0, 18'h3_3333, 2'b00, 18'h0_4444, 2'b00, 18'h0_0404, 1'b1, 1'b0, "R9 deselect after open");
    cyc(0, 18'h3_3333, 2'b00, 18'h0_4444, 2'b00, 18'h0_0505, 1'b0, 1'b0, "R2 deselected inputs ignored");
    cyc(1, 18'h1_f00d, 2'b00, 18'h2_beef, 2'b00, 18'h0_0606, 1'b1, 1'b1, "R2 no write before abort");
    cyc(0, 18'h0_0000, 2'b00, 18'h0_0000, 2'b00, 18'h0_0707, 1'b1, 1'b0, "R10 aborted transfer dropped");
    cyc(0, 18'h0_0000, 2'b00, 18'h0_0000, 2'b00, 18'h0_0808, 1'b1, 1'b0, "R10 still idle");

    for (int i = 0; i < 400; i++) rnd_cyc("R8 random stream");
    cyc(0, '0, 2'b11, '0, 2'b11, '0, 1'b1, 1'b0, "R8 flush");
    cyc(0, '0, 2'b11, '0, 2'b11, '0, 1'b1, 1'b0, "R7 final idle");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule